// File: doc/BRIEF.md
# PCI Control/Status Register Target

This block is the bus-facing side of a peripheral's control/status register space on a conventional 32-bit PCI bus. It answers configuration cycles that carry two base address registers. One register places a 4 KB memory window and the other places a 64-byte I/O window. Both windows reach the same sixteen-word register file. The memory window repeats that file every 64 bytes.

Every claimed access moves exactly one data word. The target asserts its ready and its stop signal together, so an initiator that tries to burst is disconnected after the first word. The register file stores plain data words, with two exceptions. One byte holds two enable bits that leave the block as pins. One word holds a self-timed reset trigger whose busy flag lasts a programmable number of clocks.

The shared bus lines are split into separate input and output pins with output enables. The pad ring combines them into the real tri-state signals. All bus strobes are active low.

Top module: `csr_pci_target`

## Requirements
- R1: After reset, DEVSEL#, TRDY# and STOP# read high with both output enables low. The enable pins and the busy flag read 0. Configuration dword 4 (memory base) reads 0x00000000 and dword 5 (I/O base) reads 0x00000001.
- R2: The memory base register at configuration dword 4 is writable from bit 12 upward. Bits 11:0 always read 0, so the low four type bits are hardwired to 0. Writing all ones reads back 0xFFFFF000.
- R3: The I/O base register at configuration dword 5 is writable from bit 6 upward. Bit 0 always reads 1, so writing all ones reads back 0xFFFFFFC1.
- R4: The target claims a cycle by asserting DEVSEL# on the clock after the address phase. It claims a cycle in three cases:
  - a memory read or write (command 0110 or 0111) that falls inside the memory window while command-register bit 1 is set;
  - an I/O read or write (command 0010 or 0011) that falls inside the I/O window while command-register bit 0 is set;
  - a configuration read or write (command 1010 or 1011) with IDSEL high and AD[1:0] = 00.
  The command register is configuration dword 1. Configuration dword 0 reads {DEVICE_ID, VENDOR_ID}.
- R5: The target never asserts DEVSEL# and never enables its drivers for any other cycle. This covers addresses outside both windows, a disabled space, and a configuration cycle without IDSEL.
- R6: On a claimed write, TRDY# and STOP# go low together with DEVSEL#. The word is stored on the edge where IRDY# and TRDY# are both low. Only the bytes whose C/BE# bit is low in the data phase change.
- R7: On a claimed read, DEVSEL# is low alone for one turnaround clock. TRDY# and STOP# then go low, and the AD output enable rises in the same clock.
- R8: While IRDY# is high, TRDY# stays low and no data moves.
- R9: After the one transfer, DEVSEL#, TRDY# and STOP# are driven high for one clock and then released. A FRAME# still held low after the transfer is not claimed again, and no second word is stored.
- R10: The same register is reached through I/O offset n and memory offset n. In memory space, offsets n + 64·k also reach it.
- R11: Byte offset 0xE is bits 23:16 of register word 3. Bit 16 drives rom_en and bit 17 drives clk_en. Bits 23:18 ignore writes and read 0.
- R12: Writing 1 to bit 3 of register word 7 (byte offset 0x1C) raises ctlr_rst_busy for exactly RST_CYCLES clocks, starting on the next clock. Bit 3 reads back as that flag. A trigger written while busy does not lengthen the interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_n | input | 1 | FRAME# from the initiator |
| irdy_n | input | 1 | IRDY# from the initiator |
| idsel | input | 1 | Configuration select |
| cbe_n | input | 4 | C/BE#: command in the address phase, byte enables in the data phase |
| ad_in | input | 32 | AD lines as sampled from the bus |
| ad_out | output | 32 | Read data for AD, zero when not driving |
| ad_oe | output | 1 | Drive enable for AD |
| devsel_n_out | output | 1 | DEVSEL# value |
| trdy_n_out | output | 1 | TRDY# value |
| stop_n_out | output | 1 | STOP# value |
| ctl_oe | output | 1 | Drive enable for DEVSEL#, TRDY# and STOP# |
| rom_en | output | 1 | Option ROM enable bit |
| clk_en | output | 1 | Clock enable bit |
| ctlr_rst_busy | output | 1 | Controller reset in progress |

## Verification
The checker watches the handshake on every clock. It checks that TRDY# never appears without STOP# and DEVSEL#, that AD is only driven alongside TRDY#, and that TRDY# holds through initiator wait states. It also checks that every transfer is followed by one driven-high clock and then a release, and that DEVSEL# only falls right after an address phase.

Other behaviours can only be shown by the bench's scenarios. These are window sizing and base matching, byte-lane merging, aliasing between the two spaces, the rejection of a continued burst, the reserved bits of the control byte, and the exact length of the reset-busy interval. A behavioural model compares every output on every clock while those scenarios run.

// File: rtl/csr_pci_target.sv
module csr_pci_target #(
  parameter logic [15:0] VENDOR_ID    = 16'h1D0F,
  parameter logic [15:0] DEVICE_ID    = 16'h0C5A,
  parameter int          MEM_WIN_LOG2 = 12,
  parameter int          IO_WIN_LOG2  = 6,
  parameter int          RST_CYCLES   = 250000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frame_n,
  input  logic        irdy_n,
  input  logic        idsel,
  input  logic [3:0]  cbe_n,
  input  logic [31:0] ad_in,
  output logic [31:0] ad_out,
  output logic        ad_oe,
  output logic        devsel_n_out,
  output logic        trdy_n_out,
  output logic        stop_n_out,
  output logic        ctl_oe,
  output logic        rom_en,
  output logic        clk_en,
  output logic        ctlr_rst_busy
);
  localparam int IDX_W     = IO_WIN_LOG2 - 2;
  localparam int CSR_WORDS = 1 << IDX_W;
  localparam int CNT_W     = $clog2(RST_CYCLES + 1);
  localparam int CTRL_WORD = 3;
  localparam int CTRL_LSB  = 16;
  localparam int RST_WORD  = 7;
  localparam int RST_BIT   = 3;

  typedef enum logic [1:0] {S_IDLE, S_TURN, S_DATA, S_BACK} st_t;

  st_t                   st_q;
  logic                  frame_q, rd_q, cfg_q, mem_en_q, io_en_q;
  logic [5:0]            idx_q;
  logic [31:MEM_WIN_LOG2] mem_base_q;
  logic [31:IO_WIN_LOG2]  io_base_q;
  logic [31:0]           csr_q [CSR_WORDS];
  logic [CNT_W-1:0]      rst_cnt_q;

  logic addr_ph, hit_mem, hit_io, hit_cfg, claim, xfer, wr_cfg, wr_csr, trig;
  logic [IDX_W-1:0] widx;
  logic [31:0] bmask, wmask, mem_full, io_full, mem_merge, io_merge;
  logic [31:0] cfg_rd, csr_rd;

  function automatic logic [31:0] fixed_mask(input logic [IDX_W-1:0] w);
    logic [31:0] m;
    m = '1;
    if (w == IDX_W'(CTRL_WORD)) m[CTRL_LSB+7:CTRL_LSB+2] = '0;
    if (w == IDX_W'(RST_WORD))  m[RST_BIT] = 1'b0;
    return m;
  endfunction

  assign addr_ph = (st_q == S_IDLE) && !frame_n && frame_q;
  assign hit_mem = (cbe_n[3:1] == 3'b011) && mem_en_q && (ad_in[31:MEM_WIN_LOG2] == mem_base_q);
  assign hit_io  = (cbe_n[3:1] == 3'b001) && io_en_q && (ad_in[31:IO_WIN_LOG2] == io_base_q);
  assign hit_cfg = (cbe_n[3:1] == 3'b101) && idsel && (ad_in[1:0] == 2'b00);
  assign claim   = addr_ph && (hit_mem || hit_io || hit_cfg);

  assign xfer   = (st_q == S_DATA) && !irdy_n;
  assign wr_cfg = xfer && !rd_q && cfg_q;
  assign wr_csr = xfer && !rd_q && !cfg_q;
  assign widx   = idx_q[IDX_W-1:0];
  assign bmask  = {{8{~cbe_n[3]}}, {8{~cbe_n[2]}}, {8{~cbe_n[1]}}, {8{~cbe_n[0]}}};
  assign wmask  = bmask & fixed_mask(widx);
  assign trig   = wr_csr && (widx == IDX_W'(RST_WORD)) && bmask[RST_BIT] && ad_in[RST_BIT];

  assign mem_full  = {mem_base_q, {MEM_WIN_LOG2{1'b0}}};
  assign io_full   = {io_base_q, {(IO_WIN_LOG2-1){1'b0}}, 1'b1};
  assign mem_merge = (mem_full & ~bmask) | (ad_in & bmask);
  assign io_merge  = (io_full & ~bmask) | (ad_in & bmask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      frame_q <= 1'b1;
      rd_q    <= 1'b0;
      cfg_q   <= 1'b0;
      idx_q   <= '0;
    end else begin
      frame_q <= frame_n;
      unique case (st_q)
        S_IDLE: if (claim) begin
          st_q  <= cbe_n[0] ? S_DATA : S_TURN;
          rd_q  <= !cbe_n[0];
          cfg_q <= hit_cfg;
          idx_q <= ad_in[7:2];
        end
        S_TURN: st_q <= S_DATA;
        S_DATA: if (!irdy_n) st_q <= S_BACK;
        S_BACK: st_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_en_q   <= 1'b0;
      io_en_q    <= 1'b0;
      mem_base_q <= '0;
      io_base_q  <= '0;
    end else if (wr_cfg) begin
      case (idx_q)
        6'd1: if (!cbe_n[0]) {mem_en_q, io_en_q} <= ad_in[1:0];
        6'd4: mem_base_q <= mem_merge[31:MEM_WIN_LOG2];
        6'd5: io_base_q  <= io_merge[31:IO_WIN_LOG2];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < CSR_WORDS; w++) csr_q[w] <= '0;
    end else if (wr_csr) begin
      csr_q[widx] <= (csr_q[widx] & ~wmask) | (ad_in & wmask);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      rst_cnt_q <= '0;
    else if (trig && rst_cnt_q == '0) rst_cnt_q <= CNT_W'(RST_CYCLES);
    else if (rst_cnt_q != '0)        rst_cnt_q <= rst_cnt_q - 1'b1;
  end

  always_comb begin
    case (idx_q)
      6'd0:    cfg_rd = {DEVICE_ID, VENDOR_ID};
      6'd1:    cfg_rd = {30'd0, mem_en_q, io_en_q};
      6'd4:    cfg_rd = mem_full;
      6'd5:    cfg_rd = io_full;
      default: cfg_rd = '0;
    endcase
    csr_rd = csr_q[widx];
    if (widx == IDX_W'(RST_WORD)) csr_rd[RST_BIT] = ctlr_rst_busy;
  end

  assign ctlr_rst_busy = (rst_cnt_q != '0);
  assign rom_en        = csr_q[CTRL_WORD][CTRL_LSB];
  assign clk_en        = csr_q[CTRL_WORD][CTRL_LSB+1];

  assign devsel_n_out = !((st_q == S_TURN) || (st_q == S_DATA));
  assign trdy_n_out   = (st_q != S_DATA);
  assign stop_n_out   = (st_q != S_DATA);
  assign ctl_oe       = (st_q != S_IDLE);
  assign ad_oe        = (st_q == S_DATA) && rd_q;
  assign ad_out       = ad_oe ? (cfg_q ? cfg_rd : csr_rd) : '0;
endmodule

module csr_pci_target_chk (
  input logic clk,
  input logic rst_n,
  input logic frame_n,
  input logic irdy_n,
  input logic devsel_n_out,
  input logic trdy_n_out,
  input logic stop_n_out,
  input logic ctl_oe,
  input logic ad_oe
);
  // R4
  claim_after_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(devsel_n_out) |-> $past(!frame_n));

  // R6
  ready_with_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !trdy_n_out |-> (!stop_n_out && !devsel_n_out && ctl_oe));

  // R7
  data_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |-> !trdy_n_out);

  // R8
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!trdy_n_out && irdy_n) |=> !trdy_n_out);

  // R9
  backoff_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!trdy_n_out && !irdy_n) |=> (trdy_n_out && stop_n_out && devsel_n_out && ctl_oe));

  // R9
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!trdy_n_out && !irdy_n) |=> ##1 !ctl_oe);
endmodule

bind csr_pci_target csr_pci_target_chk chk_i (
  .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
  .devsel_n_out(devsel_n_out), .trdy_n_out(trdy_n_out), .stop_n_out(stop_n_out),
  .ctl_oe(ctl_oe), .ad_oe(ad_oe)
);

// File: tb/csr_pci_target_tb_top.sv
`timescale 1ns/1ps
module csr_pci_target_tb_top;
  localparam int RSTC = 20;
  localparam logic [31:0] IDS = 32'h0C5A_1D0F;
  localparam logic [31:0] MB  = 32'hFF7F_F000;
  localparam logic [31:0] IB  = 32'h0000_DC00;

  logic clk = 1'b0, rst_n = 1'b0;
  logic frame_n = 1'b1, irdy_n = 1'b1, idsel = 1'b0;
  logic [3:0] cbe_n = 4'hF;
  logic [31:0] ad_in = '0;
  logic [31:0] ad_out;
  logic ad_oe, devsel_n_out, trdy_n_out, stop_n_out, ctl_oe, rom_en, clk_en, ctlr_rst_busy;

  int checks = 0, fails = 0, busy_cycles = 0;

  always #2 clk = ~clk;

  csr_pci_target #(.VENDOR_ID(16'h1D0F), .DEVICE_ID(16'h0C5A), .RST_CYCLES(RSTC)) dut_i (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n), .idsel(idsel),
    .cbe_n(cbe_n), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
    .devsel_n_out(devsel_n_out), .trdy_n_out(trdy_n_out), .stop_n_out(stop_n_out),
    .ctl_oe(ctl_oe), .rom_en(rom_en), .clk_en(clk_en), .ctlr_rst_busy(ctlr_rst_busy));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference: phase 0 idle, 1 turnaround, 2 data, 3 back-off
  int m_ph, m_idx, m_cnt;
  bit m_rd, m_cfg, m_fq, m_men, m_ien;
  logic [31:0] m_mbar, m_ibar;
  logic [31:0] m_csr [16];

  function automatic logic [31:0] m_read();
    logic [31:0] v;
    if (m_cfg) begin
      case (m_idx)
        0: v = IDS;
        1: v = {30'd0, m_men, m_ien};
        4: v = m_mbar;
        5: v = m_ibar | 32'h1;
        default: v = '0;
      endcase
    end else begin
      v = m_csr[m_idx % 16];
      if (m_idx % 16 == 7 && m_cnt != 0) v[3] = 1'b1;
    end
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_idx = 0; m_cnt = 0; m_rd = 0; m_cfg = 0; m_fq = 1;
      m_men = 0; m_ien = 0; m_mbar = '0; m_ibar = '0;
      for (int i = 0; i < 16; i++) m_csr[i] = '0;
    end else begin
      automatic bit xf = (m_ph == 2) && !irdy_n;
      automatic bit trg = 0;
      automatic logic [31:0] bm = {{8{~cbe_n[3]}}, {8{~cbe_n[2]}}, {8{~cbe_n[1]}}, {8{~cbe_n[0]}}};
      if (xf && !m_rd) begin
        if (m_cfg) begin
          if (m_idx == 1 && !cbe_n[0]) {m_men, m_ien} = ad_in[1:0];
          if (m_idx == 4) m_mbar = ((m_mbar & ~bm) | (ad_in & bm)) & 32'hFFFF_F000;
          if (m_idx == 5) m_ibar = ((m_ibar & ~bm) | (ad_in & bm)) & 32'hFFFF_FFC0;
        end else begin
          automatic int w = m_idx % 16;
          automatic logic [31:0] km = bm;
          if (w == 3) km = km & ~32'h00FC_0000;
          if (w == 7) begin km = km & ~32'h8; trg = bm[3] && ad_in[3]; end
          m_csr[w] = (m_csr[w] & ~km) | (ad_in & km);
        end
      end
      if (trg && m_cnt == 0) m_cnt = RSTC;
      else if (m_cnt != 0) m_cnt = m_cnt - 1;
      case (m_ph)
        0: if (!frame_n && m_fq) begin
          automatic bit hm = (cbe_n[3:1] == 3'b011) && m_men && ((ad_in & 32'hFFFF_F000) == m_mbar);
          automatic bit hi = (cbe_n[3:1] == 3'b001) && m_ien && ((ad_in & 32'hFFFF_FFC0) == m_ibar);
          automatic bit hc = (cbe_n[3:1] == 3'b101) && idsel && (ad_in[1:0] == 2'b00);
          if (hm || hi || hc) begin
            m_rd = !cbe_n[0]; m_cfg = hc; m_idx = int'(ad_in[7:2]);
            m_ph = m_rd ? 1 : 2;
          end
        end
        1: m_ph = 2;
        2: if (!irdy_n) m_ph = 3;
        default: m_ph = 0;
      endcase
      m_fq = frame_n;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      automatic bit eoe = (m_ph == 2) && m_rd;
      chk("R4 devsel", {31'd0, devsel_n_out}, {31'd0, !(m_ph == 1 || m_ph == 2)});
      chk("R6 trdy", {31'd0, trdy_n_out}, {31'd0, m_ph != 2});
      chk("R9 stop", {31'd0, stop_n_out}, {31'd0, m_ph != 2});
      chk("R9 ctl_oe", {31'd0, ctl_oe}, {31'd0, m_ph != 0});
      chk("R7 ad_oe", {31'd0, ad_oe}, {31'd0, eoe});
      chk("R7 ad_out", ad_out, eoe ? m_read() : 32'h0);
      chk("R11 enables", {30'd0, clk_en, rom_en}, {30'd0, m_csr[3][17], m_csr[3][16]});
      chk("R12 busy", {31'd0, ctlr_rst_busy}, {31'd0, m_cnt != 0});
      if (ctlr_rst_busy) busy_cycles++;
    end
  end

  task automatic access(input logic [3:0] cmd, input logic [31:0] addr, input logic [31:0] wdata,
                        input logic [3:0] be_n, input bit sel, input int waits, input bit burst,
                        output logic [31:0] rdata, output bit claimed, output int lat);
    bit done = 0;
    int wt = waits;
    claimed = 0; rdata = '0; lat = -1;
    @(negedge clk);
    frame_n = 1'b0; ad_in = addr; cbe_n = cmd; idsel = sel;
    @(negedge clk);
    frame_n = burst ? 1'b0 : 1'b1; cbe_n = be_n; ad_in = wdata; idsel = 1'b0;
    irdy_n = (wt == 0) ? 1'b0 : 1'b1;
    for (int i = 0; i < 8 && !done; i++) begin
      if (!devsel_n_out) claimed = 1;
      if (!trdy_n_out && !irdy_n) begin rdata = ad_out; lat = i; done = 1; end
      @(negedge clk);
      if (!done) begin
        if (wt > 0) wt--;
        irdy_n = (wt == 0) ? 1'b0 : 1'b1;
      end
    end
    if (done && burst) begin
      ad_in = ~wdata;
      repeat (2) @(negedge clk);
    end
    frame_n = 1'b1; irdy_n = 1'b1; ad_in = '0; cbe_n = 4'hF;
  endtask

  logic [31:0] rd;
  bit cl;
  int lt;

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 strobes", {29'd0, devsel_n_out, trdy_n_out, stop_n_out}, 32'h7);
    chk("R1 enables", {27'd0, ctl_oe, ad_oe, rom_en, clk_en, ctlr_rst_busy}, 32'h0);
    access(4'b1010, 32'h0, 0, 4'h0, 1, 0, 0, rd, cl, lt);
    chk("R4 cfg claim", {31'd0, cl}, 32'h1);
    chk("R4 id word", rd, IDS);
    chk("R7 read latency", lt, 1);
    access(4'b1010, 32'h10, 0, 4'h0, 1, 0, 0, rd, cl, lt);
    chk("R1 mem bar reset", rd, 32'h0);
    access(4'b1010, 32'h14, 0, 4'h0, 1, 0, 0, rd, cl, lt);
    chk("R1 io bar reset", rd, 32'h1);
    // R2 / R3 sizing
    access(4'b1011, 32'h10, 32'hFFFF_FFFF, 4'h0, 1, 0, 0, rd, cl, lt);
    chk("R6 write latency", lt, 0);
    access(4'b1010, 32'h10, 0, 4'h0, 1, 0, 0, rd, cl, lt);
    chk("R2 mem size", rd, 32'hFFFF_F000);
    access(4'b1011, 32'h14, 32'hFFFF_FFFF, 4'h0, 1, 0, 0, rd, cl, lt);
    access(4'b1010, 32'h14, 0, 4'h0, 1, 0, 0, rd, cl, lt);
    chk("R3 io size", rd, 32'hFFFF_FFC1);
    access(4'b1011, 32'h10, MB | 32'hF, 4'h0, 1, 0, 0, rd, cl, lt);
    access(4'b1010, 32'h10, 0, 4'h0, 1, 0, 0, rd, cl, lt);
    chk("R2 low bits hardwired", rd, MB);
    access(4'b1011, 32'h14, IB, 4'h0, 1, 0, 0, rd, cl, lt);
    // R5 spaces disabled
    access(4'b0111, MB + 8, 32'h1, 4'h0, 0, 0, 0, rd, cl, lt);
    chk("R5 mem disabled", {31'd0, cl}, 32'h0);
    access(4'b1011, 32'h04, 32'h1, 4'hE, 1, 0, 0, rd, cl, lt);
    access(4'b0111, MB + 8, 32'h1, 4'h0, 0, 0, 0, rd, cl, lt);
    chk("R5 mem still disabled", {31'd0, cl}, 32'h0);
    access(4'b1011, 32'h04, 32'h3, 4'hE, 1, 0, 0, rd, cl, lt);
    // R6 / R10
    access(4'b0111, MB + 8, 32'hA5A5_1234, 4'h0, 0, 0, 0, rd, cl, lt);
    chk("R4 mem claim", {31'd0, cl}, 32'h1);
    access(4'b0010, IB + 8, 0, 4'h0, 0, 0, 0, rd, cl, lt);
    chk("R10 io sees mem write", rd, 32'hA5A5_1234);
    access(4'b0011, IB + 8, 32'h1122_3344, 4'b1010, 0, 0, 0, rd, cl, lt);
    access(4'b0110, MB + 8, 0, 4'h0, 0, 0, 0, rd, cl, lt);
    chk("R6 byte lanes", rd, 32'hA522_1244);
    access(4'b0110, MB + 32'h48, 0, 4'h0, 0, 0, 0, rd, cl, lt);
    chk("R10 alias +64", rd, 32'hA522_1244);
    access(4'b0110, MB + 32'hFC8, 0, 4'h0, 0, 0, 0, rd, cl, lt);
    chk("R10 alias top", rd, 32'hA522_1244);
    // R8 wait states
    access(4'b0111, MB + 32'h14, 32'hCAFE_F00D, 4'h0, 0, 3, 0, rd, cl, lt);
    chk("R8 waited write latency", lt, 3);
    access(4'b0010, IB + 32'h14, 0, 4'h0, 0, 2, 0, rd, cl, lt);
    chk("R8 waited read", rd, 32'hCAFE_F00D);
    // R5 misses
    access(4'b0111, 32'hFF7F_E000, 32'h5, 4'h0, 0, 0, 0, rd, cl, lt);
    chk("R5 mem miss", {31'd0, cl}, 32'h0);
    access(4'b0011, IB + 32'h40, 32'h5, 4'h0, 0, 0, 0, rd, cl, lt);
    chk("R5 io miss", {31'd0, cl}, 32'h0);
    access(4'b1010, 32'h0, 0, 4'h0, 0, 0, 0, rd, cl, lt);
    chk("R5 cfg no idsel", {31'd0, cl}, 32'h0);
    // R11 control byte
    access(4'b0011, IB + 32'hC, 32'hFFFF_FFFF, 4'b1011, 0, 0, 0, rd, cl, lt);
    chk("R11 both set", {30'd0, clk_en, rom_en}, 32'h3);
    access(4'b0010, IB + 32'hC, 0, 4'h0, 0, 0, 0, rd, cl, lt);
    chk("R11 reserved read 0", rd, 32'h0003_0000);
    access(4'b0111, MB + 32'hC, 32'h0001_0000, 4'b1011, 0, 0, 0, rd, cl, lt);
    chk("R11 rom only", {30'd0, clk_en, rom_en}, 32'h1);
    // R9 burst attempt
    access(4'b0111, MB + 32'h18, 32'h1234_5678, 4'h0, 0, 0, 1, rd, cl, lt);
    access(4'b0110, MB + 32'h18, 0, 4'h0, 0, 0, 0, rd, cl, lt);
    chk("R9 single word only", rd, 32'h1234_5678);
    // R12 reset trigger
    busy_cycles = 0;
    access(4'b0011, IB + 32'h1C, 32'h0000_0008, 4'h0, 0, 0, 0, rd, cl, lt);
    chk("R12 busy raised", {31'd0, ctlr_rst_busy}, 32'h1);
    access(4'b0010, IB + 32'h1C, 0, 4'h0, 0, 0, 0, rd, cl, lt);
    chk("R12 bit3 reads busy", rd, 32'h8);
    access(4'b0011, IB + 32'h1C, 32'h0000_0008, 4'h0, 0, 0, 0, rd, cl, lt);
    repeat (2 * RSTC) @(negedge clk);
    chk("R12 busy length", busy_cycles, RSTC);
    access(4'b0010, IB + 32'h1C, 0, 4'h0, 0, 0, 0, rd, cl, lt);
    chk("R12 bit3 clear", rd, 32'h0);
    repeat (3) @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule